// File: doc/BRIEF.md
# Byte ALU with Status Flags and Branch Condition Evaluator

This block performs one arithmetic or logical operation on two operands and derives six status flags from it: carry, parity, half-carry, zero, sign and signed overflow. The operations are addition, subtraction, compare, bitwise AND, OR and XOR, a non-writing bit test, and two's-complement negation. The result and its write-enable leave the block in the same cycle, with no register in between. The flags are captured in a flag register on the clock edge where `op_valid` is high.

A condition evaluator reads the stored flags and a 4-bit condition code and reports whether a conditional branch with that code would be taken. The stored flags feed both the evaluator and the flag outputs, so a compare followed by a branch test works the same way as a compare-and-jump pair in a processor pipeline. The datapath width is a parameter with a default of 8 bits. Parity always covers the low 8 bits of the result, and the half-carry always comes from the low 4 bits.

Top module: `alu_flag_unit`

## Requirements
- R1: ADD (op_sel 0) gives result = (op_a + op_b) mod 2^WIDTH. CF is the unsigned carry out, so 0xFF + 0x01 gives result 0x00 with CF=1 and ZF=1.
- R2: SUB (op_sel 1) and CMP (op_sel 2) give result = op_a − op_b mod 2^WIDTH, with CF=1 when op_a < op_b unsigned. CMP sets every flag exactly as SUB does, but it drives result_we low.
- R3: For ADD, SUB, CMP and NEG, OF=1 exactly when the true signed two's-complement result falls outside the WIDTH-bit signed range. For example, 0x64 + 0x32 (100 + 50) sets OF.
- R4: AF=1 when the low 4 bits produce a carry out (ADD) or need a borrow (SUB, CMP, NEG). AF=0 after AND, OR, XOR and TEST.
- R5: PF=1 when the low 8 result bits hold an even number of ones. ZF=1 exactly when the whole result is zero. SF equals the result's most significant bit.
- R6: AND (3), OR (4) and XOR (5) clear CF and OF. TEST (6) sets every flag as AND does and drives result_we low. result_we = op_valid for ADD, SUB, logic ops and NEG.
- R7: NEG (op_sel 7) gives result = 0 − op_a. CF=1 unless op_a is zero. OF=1 only for op_a = 0x80 (the most negative value).
- R8: While rst_n is low the flag register holds all zeros. It loads new flags on a rising clock edge with op_valid high, and it keeps its value on edges with op_valid low.
- R9: branch_taken is a combinational function of the stored flags and cond_sel. Bits [3:1] select the base term: 0 OF, 1 CF, 2 ZF, 3 CF|ZF, 4 SF, 5 PF, 6 SF^OF, 7 ZF|(SF^OF). Bit 0 inverts the base term, so code 9 (not-sign) is taken when SF=0.
- R10: Code 15 (signed greater) is taken when ZF=0 and SF=OF. After CMP with op_a=0x02 and op_b=0xC0 it is taken, because the operands are compared as two's complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Active-low reset of the flag register |
| op_valid | input | 1 | Qualifies the operation; loads flags at the edge |
| op_sel | input | 3 | Operation select (encoding in R1–R7 entries) |
| op_a | input | WIDTH | First operand (sole operand of NEG) |
| op_b | input | WIDTH | Second operand |
| cond_sel | input | 4 | Branch condition code |
| result | output | WIDTH | Combinational operation result |
| result_we | output | 1 | Result write-enable |
| flag_cf | output | 1 | Stored carry/borrow flag |
| flag_pf | output | 1 | Stored even-parity flag |
| flag_af | output | 1 | Stored nibble carry/borrow flag |
| flag_zf | output | 1 | Stored zero flag |
| flag_sf | output | 1 | Stored sign flag |
| flag_of | output | 1 | Stored signed-overflow flag |
| branch_taken | output | 1 | Condition result from stored flags |

## Verification
The result and result_we are due in the same cycle the operands and op_sel are applied, so the bench samples them a short delay after driving, well before the next rising edge. The flags are due one rising edge after op_valid, so the bench samples them just after that edge. Branch evaluation depends only on the stored flags, so after each edge the bench sweeps all sixteen condition codes against its own flag model, with a settling delay between codes.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

   typedef enum logic [2:0] {
      OP_ADD  = 3'd0,
      OP_SUB  = 3'd1,
      OP_CMP  = 3'd2,
      OP_AND  = 3'd3,
      OP_OR   = 3'd4,
      OP_XOR  = 3'd5,
      OP_TEST = 3'd6,
      OP_NEG  = 3'd7
   } alu_op_e;

   typedef enum logic [3:0] {
      CC_OVF  = 4'd0,  CC_NOVF = 4'd1,
      CC_CY   = 4'd2,  CC_NCY  = 4'd3,
      CC_EQ   = 4'd4,  CC_NE   = 4'd5,
      CC_ULE  = 4'd6,  CC_UGT  = 4'd7,
      CC_NEG  = 4'd8,  CC_POS  = 4'd9,
      CC_PEV  = 4'd10, CC_POD  = 4'd11,
      CC_SLT  = 4'd12, CC_SGE  = 4'd13,
      CC_SLE  = 4'd14, CC_SGT  = 4'd15
   } cond_e;

   typedef struct packed {
      logic of;
      logic sf;
      logic zf;
      logic af;
      logic pf;
      logic cf;
   } flags_t;

   localparam int PARITY_SPAN = 8;
   localparam int NIBBLE_SPAN = 4;

   function automatic logic op_is_logic(alu_op_e op);
      return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR) || (op == OP_TEST);
   endfunction

   function automatic logic op_writes_back(alu_op_e op);
      return (op != OP_CMP) && (op != OP_TEST);
   endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
   parameter int WIDTH = 8,
   parameter int NIB   = 4
) (
   input  logic [WIDTH-1:0] in_a,
   input  logic [WIDTH-1:0] in_b,
   input  logic             subtract,
   output logic [WIDTH-1:0] sum,
   output logic             carry,
   output logic             half,
   output logic             ovf
);
   logic [WIDTH-1:0] b_eff;
   logic [WIDTH:0]   full;
   logic [WIDTH-1:0] body;
   logic [NIB:0]     low;

   assign b_eff = subtract ? ~in_b : in_b;

   // full-width sum with carry-in for two's complement subtraction
   assign full = {1'b0, in_a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, subtract};
   // sum of all bits below the MSB: its top bit is the carry into the MSB
   assign body = {1'b0, in_a[WIDTH-2:0]} + {1'b0, b_eff[WIDTH-2:0]}
               + {{(WIDTH-1){1'b0}}, subtract};
   // low nibble sum for the half-carry
   assign low  = {1'b0, in_a[NIB-1:0]} + {1'b0, b_eff[NIB-1:0]}
               + {{NIB{1'b0}}, subtract};

   assign sum   = full[WIDTH-1:0];
   assign carry = full[WIDTH] ^ subtract;
   assign half  = low[NIB] ^ subtract;
   assign ovf   = full[WIDTH] ^ body[WIDTH-1];

endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] in_a,
   input  logic [WIDTH-1:0] in_b,
   input  logic [1:0]       func,
   output logic [WIDTH-1:0] res
);
   // func: 0 and, 1 or, 2 xor, 3 and (test)
   genvar gi;
   generate
      for (gi = 0; gi < WIDTH; gi++) begin : g_bit
         always_comb begin
            unique case (func)
               2'd1:    res[gi] = in_a[gi] | in_b[gi];
               2'd2:    res[gi] = in_a[gi] ^ in_b[gi];
               default: res[gi] = in_a[gi] & in_b[gi];
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/alu_parity.sv
module alu_parity #(
   parameter int WIDTH = 8,
   parameter int SPAN  = 8
) (
   input  logic [WIDTH-1:0] value,
   output logic             even
);
   logic [SPAN:0] chain;

   assign chain[0] = 1'b1;

   genvar gi;
   generate
      for (gi = 0; gi < SPAN; gi++) begin : g_link
         assign chain[gi+1] = chain[gi] ^ value[gi];
      end
   endgenerate

   assign even = chain[SPAN];

endmodule

// File: rtl/alu_cond_eval.sv
module alu_cond_eval
   import alu_flag_pkg::*;
(
   input  flags_t     flags,
   input  logic [3:0] cond,
   output logic       taken
);
   logic base;
   logic signed_lt;

   assign signed_lt = flags.sf ^ flags.of;

   always_comb begin
      unique case (cond[3:1])
         3'd0: base = flags.of;
         3'd1: base = flags.cf;
         3'd2: base = flags.zf;
         3'd3: base = flags.cf | flags.zf;
         3'd4: base = flags.sf;
         3'd5: base = flags.pf;
         3'd6: base = signed_lt;
         default: base = flags.zf | signed_lt;
      endcase
   end

   assign taken = base ^ cond[0];

endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
   import alu_flag_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             op_valid,
   input  logic [2:0]       op_sel,
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  logic [3:0]       cond_sel,
   output logic [WIDTH-1:0] result,
   output logic             result_we,
   output logic             flag_cf,
   output logic             flag_pf,
   output logic             flag_af,
   output logic             flag_zf,
   output logic             flag_sf,
   output logic             flag_of,
   output logic             branch_taken
);
   localparam int MSB = WIDTH - 1;

   generate
      if (WIDTH < PARITY_SPAN) begin : g_bad_width
         $error("alu_flag_unit: WIDTH must be at least PARITY_SPAN");
      end
   endgenerate

   alu_op_e          op;
   logic [WIDTH-1:0] as_a, as_b, as_sum, lg_res;
   logic             as_sub, as_carry, as_half, as_ovf;
   logic             is_logic, par_even;
   flags_t           flags_q, flags_d;

   assign op       = alu_op_e'(op_sel);
   assign is_logic = op_is_logic(op);

   // NEG runs as 0 - op_a through the shared adder
   assign as_a   = (op == OP_NEG) ? '0 : op_a;
   assign as_b   = (op == OP_NEG) ? op_a : op_b;
   assign as_sub = (op != OP_ADD);

   alu_addsub #(.WIDTH(WIDTH), .NIB(NIBBLE_SPAN)) i_addsub (
      .in_a     (as_a),
      .in_b     (as_b),
      .subtract (as_sub),
      .sum      (as_sum),
      .carry    (as_carry),
      .half     (as_half),
      .ovf      (as_ovf)
   );

   logic [1:0] lg_func;
   always_comb begin
      unique case (op)
         OP_OR:   lg_func = 2'd1;
         OP_XOR:  lg_func = 2'd2;
         default: lg_func = 2'd0;
      endcase
   end

   alu_logic #(.WIDTH(WIDTH)) i_logic (
      .in_a (op_a),
      .in_b (op_b),
      .func (lg_func),
      .res  (lg_res)
   );

   assign result    = is_logic ? lg_res : as_sum;
   assign result_we = op_valid && op_writes_back(op);

   alu_parity #(.WIDTH(WIDTH), .SPAN(PARITY_SPAN)) i_parity (
      .value (result),
      .even  (par_even)
   );

   always_comb begin
      flags_d.pf = par_even;
      flags_d.zf = (result == '0);
      flags_d.sf = result[MSB];
      if (is_logic) begin
         flags_d.cf = 1'b0;
         flags_d.of = 1'b0;
         flags_d.af = 1'b0;
      end else begin
         flags_d.cf = as_carry;
         flags_d.of = as_ovf;
         flags_d.af = as_half;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flags_q <= '0;
      else if (op_valid) flags_q <= flags_d;
   end

   assign flag_cf = flags_q.cf;
   assign flag_pf = flags_q.pf;
   assign flag_af = flags_q.af;
   assign flag_zf = flags_q.zf;
   assign flag_sf = flags_q.sf;
   assign flag_of = flags_q.of;

   alu_cond_eval i_cond (
      .flags (flags_q),
      .cond  (cond_sel),
      .taken (branch_taken)
   );

   // ---------------- assertions ----------------
   assert_logic_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && is_logic) |=> (!flag_cf && !flag_of && !flag_af));

   assert_zero_matches_R5: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |=> (flag_zf == ($past(result) == '0)));

   assert_sign_matches_R5: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |=> (flag_sf == $past(result[MSB])));

   assert_neg_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op == OP_NEG) |=> (flag_cf == ($past(op_a) != '0)));

   assert_hold_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> $stable(flags_q));

   assert_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_CMP || op == OP_TEST) |-> !result_we);

   assert_not_sign_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cond_sel == CC_POS) |-> (branch_taken == !flag_sf));

   assert_signed_gt_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cond_sel == CC_SGT) |-> (branch_taken == (!flag_zf && (flag_sf == flag_of))));

endmodule

// File: tb/test_alu_flag_unit.sv
module test_alu_flag_unit;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       op_valid = 1'b0;
   logic [2:0] op_sel = 3'd0;
   logic [7:0] op_a = 8'd0, op_b = 8'd0;
   logic [3:0] cond_sel = 4'd0;
   logic [7:0] result;
   logic       result_we, flag_cf, flag_pf, flag_af, flag_zf, flag_sf, flag_of;
   logic       branch_taken;

   int checks = 0;
   int errors = 0;

   // reference flag state
   int m_cf = 0, m_pf = 0, m_af = 0, m_zf = 0, m_sf = 0, m_of = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   alu_flag_unit #(.WIDTH(8)) i_alu_flag_unit (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
      .op_a(op_a), .op_b(op_b), .cond_sel(cond_sel), .result(result),
      .result_we(result_we), .flag_cf(flag_cf), .flag_pf(flag_pf),
      .flag_af(flag_af), .flag_zf(flag_zf), .flag_sf(flag_sf),
      .flag_of(flag_of), .branch_taken(branch_taken)
   );

   task automatic check(string req, string what, int actual, int expected);
      checks++;
      if (actual != expected) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, actual, expected);
      end
   endtask

   function automatic int sx(int v);
      return (v > 127) ? v - 256 : v;
   endfunction

   function automatic int model_branch(int c);
      int b;
      case (c / 2)
         0: b = m_of;
         1: b = m_cf;
         2: b = m_zf;
         3: b = m_cf | m_zf;
         4: b = m_sf;
         5: b = m_pf;
         6: b = (m_sf != m_of) ? 1 : 0;
         default: b = (m_zf == 1 || m_sf != m_of) ? 1 : 0;
      endcase
      return (c % 2 == 1) ? 1 - b : b;
   endfunction

   task automatic check_flags(string rc, string ra, string rf, string ro);
      check(rc, "CF", int'(flag_cf), m_cf);
      check(ra, "AF", int'(flag_af), m_af);
      check(rf, "PF", int'(flag_pf), m_pf);
      check(rf, "ZF", int'(flag_zf), m_zf);
      check(rf, "SF", int'(flag_sf), m_sf);
      check(ro, "OF", int'(flag_of), m_of);
      for (int c = 0; c < 16; c++) begin
         cond_sel = 4'(c);
         #1;
         check("R9", $sformatf("branch cond %0d", c), int'(branch_taken), model_branch(c));
      end
   endtask

   task automatic step(int op, int a, int b, bit valid);
      int r, cf, af, of, sv, ones, x, y;
      string rc, ro;
      @(negedge clk);
      op_sel = 3'(op); op_a = 8'(a); op_b = 8'(b); op_valid = valid;
      x = a; y = b;
      if (op == 7) begin x = 0; y = a; end
      cf = 0; af = 0; of = 0;
      case (op)
         0: begin
            r = (x + y) % 256; cf = (x + y > 255);
            af = ((x % 16) + (y % 16) > 15);
            sv = sx(x) + sx(y); of = (sv > 127 || sv < -128);
         end
         1, 2, 7: begin
            r = (x - y + 256) % 256; cf = (x < y);
            af = ((x % 16) < (y % 16));
            sv = sx(x) - sx(y); of = (sv > 127 || sv < -128);
         end
         4: r = a | b;
         5: r = a ^ b;
         default: r = a & b;
      endcase
      #2;
      rc = (op == 0) ? "R1" : (op == 7) ? "R7" : (op >= 3) ? "R6" : "R2";
      check(rc, "result", int'(result), r);
      check((op == 2 || op >= 3 && op <= 6) ? "R6" : "R2", "result_we",
            int'(result_we), (valid && op != 2 && op != 6) ? 1 : 0);
      if (valid) begin
         ones = 0;
         for (int i = 0; i < 8; i++) ones += (r >> i) & 1;
         m_cf = cf; m_af = af; m_of = of;
         m_pf = (ones % 2 == 0); m_zf = (r == 0); m_sf = (r >= 128);
      end
      @(posedge clk);
      #2;
      op_valid = 1'b0;
      if (!valid) check_flags("R8", "R8", "R8", "R8");
      else begin
         ro = (op >= 3 && op <= 6) ? "R6" : (op == 7) ? "R7" : "R3";
         check_flags(rc, (op >= 3 && op <= 6) ? "R6" : "R4", "R5", ro);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int seed;
      repeat (2) @(posedge clk);
      #2;
      check_flags("R8", "R8", "R8", "R8");   // reset state, all zero
      @(negedge clk);
      rst_n = 1'b1;

      step(0, 8'hFF, 8'h01, 1);              // R1 carry out, zero
      check("R1", "CF on FF+01", int'(flag_cf), 1);
      step(0, 8'h64, 8'h32, 1);              // R3 100+50
      check("R3", "OF on 100+50", int'(flag_of), 1);
      step(0, 8'h0F, 8'h01, 1);              // R4 nibble carry
      step(1, 8'h05, 8'h07, 1);              // R2 borrow
      step(1, 8'h10, 8'h01, 1);              // R4 nibble borrow
      step(1, 8'h80, 8'h01, 1);              // R3 signed overflow on subtract
      step(2, 8'h02, 8'hC0, 1);              // R10 signed compare
      cond_sel = 4'd15; #1;
      check("R10", "signed greater 02 vs C0", int'(branch_taken), 1);
      step(3, 8'hF0, 8'h3C, 1);              // R6 and
      step(4, 8'h81, 8'h02, 1);              // R6 or
      step(5, 8'hAA, 8'hAA, 1);              // R6 xor -> zero
      step(6, 8'h80, 8'hC0, 1);              // R6 test
      step(7, 8'h00, 8'h00, 1);              // R7 zero operand
      step(7, 8'h80, 8'h00, 1);              // R7 most negative
      step(7, 8'h01, 8'h00, 1);              // R7
      step(0, 8'h7F, 8'h01, 0);              // R8 hold
      step(7, 8'h00, 8'h55, 0);              // R8 hold

      seed = 32'h1234;
      for (int n = 0; n < 300; n++) begin
         seed = seed * 1103515245 + 12345;
         step((seed >>> 8) & 7, (seed >>> 12) & 255, (seed >>> 20) & 255,
              ((seed >>> 29) & 3) != 0);
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule